// File: doc/BRIEF.md
# Memory Chip-Select and Wait-State Generator

This block sits between a small processor and its memories. It watches the five most significant address lines together with the active-low read and write strobes, and it decodes them into three active-low chip selects: one for a ROM window and one for each of two RAM banks. The chip-select decode is purely combinational, so a select follows the address and strobes within the same cycle.

ROM is assumed to be slower than the processor bus. Whenever a read targets the ROM window, a two-stage registered wait chain holds the READY line low for two clocks before releasing it. READY is only driven while such a read is in progress. Outside ROM reads the line is meant to float, and this is modelled by a separate output-enable port. A synchronous reset returns the wait chain to its waiting state.

The wait chain is a three-state machine whose state is the pair (first stage, second stage). WS_IDLE (both stages set) is the resting state. WS_HALF (first stage cleared, second still set) marks one elapsed wait clock. WS_GO (both cleared) lets READY rise. The transitions are as follows. WS_IDLE goes to WS_HALF on a ROM read. WS_HALF goes to WS_GO on a continuing ROM read. WS_GO stays in WS_GO while the read continues. Every state returns to WS_IDLE when the ROM read ends or reset is high.

Top module: `memsel_waitgen`

## Requirements
- R1: `rom_cs_n` is 0 exactly when `rd_n` is 0 and `addr_hi[4:2]` equals 3'b000, where `addr_hi[4]` is the most significant address line. A write alone never selects ROM.
- R2: `ram0_cs_n` is 0 exactly when `addr_hi` equals 5'b00100 and at least one of `rd_n` and `wr_n` is 0.
- R3: `ram1_cs_n` is 0 exactly when `addr_hi` equals 5'b00101 and at least one of `rd_n` and `wr_n` is 0.
- R4: `ready_oe` is 1 in exactly the cycles where the ROM select condition of R1 holds, in the same cycle.
- R5: On the first cycle of a ROM read that follows a cycle without one, `ready` is 0.
- R6: While a ROM read is held on consecutive cycles, `ready` is 0 in its first and second cycles and 1 from the third cycle on, for as long as the read lasts.
- R7: While `rst` is 1 at a rising clock edge, the wait chain returns to its waiting state, so `ready` is 0 in the following cycle whatever the other inputs are.
- R8: Reads or writes outside the ROM window, and writes inside it, keep `ready_oe` at 0.
- R9: Any single cycle without a ROM read, including a move to another address, restarts the wait count, so the next ROM read again sees two low cycles of `ready`.
- R10: At most one of the three chip selects is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_hi | input | 5 | Upper address lines, bit 4 most significant |
| rd_n | input | 1 | Memory read strobe, active low |
| wr_n | input | 1 | Memory write strobe, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram0_cs_n | output | 1 | RAM bank 0 chip select, active low |
| ram1_cs_n | output | 1 | RAM bank 1 chip select, active low |
| ready | output | 1 | Bus ready level, meaningful when `ready_oe` is 1 |
| ready_oe | output | 1 | Drive enable for `ready`; 0 means the line floats |

## Verification
Long ROM reads of five cycles tell a correct two-clock delay apart from one that releases too early, too late, or oscillates. Single-cycle breaks and moves from the ROM window to a RAM address show whether the count restarts. Reads and writes to each RAM bank, to unmapped addresses and to the ROM window check that the decode depends on both address and strobe. A reset asserted during a held ROM read checks that the chain re-arms. Random traffic tends to keep the same inputs across cycles, so ROM reads of many different lengths occur, and every cycle is compared against a reference counter that runs in the bench.

// File: rtl/memsel_pkg.sv
`timescale 1ns/1ps
package memsel_pkg;

    // Address decode geometry
    localparam int UPPER_W   = 5;
    localparam int ROM_KEY_W = 3;
    localparam logic [ROM_KEY_W-1:0] ROM_KEY = 3'b000;

    localparam int RAM_BANKS = 2;
    localparam int BANK_W    = $clog2(RAM_BANKS);
    localparam int RAM_KEY_W = UPPER_W - BANK_W;
    localparam logic [RAM_KEY_W-1:0] RAM_KEY = 4'b0010;

    // Wait chain state; encoding is {first stage, second stage}
    typedef enum logic [1:0] {
        WS_IDLE = 2'b11,
        WS_HALF = 2'b01,
        WS_GO   = 2'b00
    } wstate_t;

endpackage

// File: rtl/memsel_decode.sv
`timescale 1ns/1ps
module memsel_decode
    import memsel_pkg::*;
(
    input  logic [UPPER_W-1:0]  addr_hi,
    input  logic                rd_n,
    input  logic                wr_n,
    output logic                rom_hit,
    output logic [RAM_BANKS-1:0] ram_hit
);

    logic rd_act;
    logic acc_act;

    assign rd_act  = ~rd_n;
    assign acc_act = ~rd_n | ~wr_n;

    // ROM window: only reads qualify
    assign rom_hit = rd_act && (addr_hi[UPPER_W-1 -: ROM_KEY_W] == ROM_KEY);

    // One decoder per RAM bank, bank index in the low address bits
    for (genvar b = 0; b < RAM_BANKS; b++) begin : g_bank
        assign ram_hit[b] = acc_act
                         && (addr_hi[UPPER_W-1 -: RAM_KEY_W] == RAM_KEY)
                         && (addr_hi[BANK_W-1:0] == BANK_W'(b));
    end

endmodule

// File: rtl/memsel_wait_fsm.sv
`timescale 1ns/1ps
module memsel_wait_fsm
    import memsel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rom_rd,
    output logic stage1,
    output logic stage2
);

    wstate_t st;
    wstate_t st_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= WS_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Next state
    always_comb begin
        st_nx = WS_IDLE;
        if (rom_rd) begin
            unique case (st)
                WS_IDLE: st_nx = WS_HALF;
                WS_HALF: st_nx = WS_GO;
                WS_GO:   st_nx = WS_GO;
                default: st_nx = WS_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (st)
            WS_IDLE: begin stage1 = 1'b1; stage2 = 1'b1; end
            WS_HALF: begin stage1 = 1'b0; stage2 = 1'b1; end
            WS_GO:   begin stage1 = 1'b0; stage2 = 1'b0; end
            default: begin stage1 = 1'b1; stage2 = 1'b1; end
        endcase
    end

    // R7: reset re-arms the chain
    p_reset_rearm_r7: assert property (@(posedge clk)
        rst |=> (stage1 && stage2));

    // R9: a cycle without a ROM read restarts the count
    p_break_restart_r9: assert property (@(posedge clk) disable iff (rst)
        !rom_rd |=> (stage1 && stage2));

    // R5: a fresh ROM read sees the second stage still set
    p_first_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (rom_rd && !$past(rom_rd)) |-> stage2);

    // R6: the first stage clears one clock before the second
    p_stage_order_r6: assert property (@(posedge clk) disable iff (rst)
        (rom_rd && stage1) |=> (!stage1 && stage2) || !rom_rd);

endmodule

// File: rtl/memsel_waitgen.sv
`timescale 1ns/1ps
module memsel_waitgen
    import memsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [4:0]         addr_hi,
    input  logic               rd_n,
    input  logic               wr_n,
    output logic               rom_cs_n,
    output logic               ram0_cs_n,
    output logic               ram1_cs_n,
    output logic               ready,
    output logic               ready_oe
);

    logic                 rom_hit;
    logic [RAM_BANKS-1:0] ram_hit;
    logic                 stage1;
    logic                 stage2;

    memsel_decode u_decode (
        .addr_hi (addr_hi),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .rom_hit (rom_hit),
        .ram_hit (ram_hit)
    );

    memsel_wait_fsm u_wait (
        .clk    (clk),
        .rst    (rst),
        .rom_rd (rom_hit),
        .stage1 (stage1),
        .stage2 (stage2)
    );

    assign rom_cs_n  = ~rom_hit;
    assign ram0_cs_n = ~ram_hit[0];
    assign ram1_cs_n = ~ram_hit[1];
    assign ready_oe  = rom_hit;
    assign ready     = ~stage2;

    // R10: chip selects never overlap
    p_single_select_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({~rom_cs_n, ~ram0_cs_n, ~ram1_cs_n}) <= 1);

    // R6: a driven high ready needs two prior driven cycles
    p_ready_history_r6: assert property (@(posedge clk) disable iff (rst)
        (ready_oe && ready) |-> ($past(ready_oe) && $past(ready_oe, 2)));

    // R6: ready only rises once the first stage has cleared
    p_ready_after_stage1_r6: assert property (@(posedge clk) disable iff (rst)
        ready |-> !stage1);

endmodule

// File: tb/test_memsel_waitgen.sv
`timescale 1ns/1ps
module test_memsel_waitgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] addr_hi = 5'b11111;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rom_cs_n, ram0_cs_n, ram1_cs_n, ready, ready_oe;

    int total = 0;
    int bad   = 0;
    int cnt   = 0;
    bit valid = 1'b0;

    always #2.5 clk = ~clk;

    memsel_waitgen i_memsel_waitgen (
        .clk       (clk),
        .rst       (rst),
        .addr_hi   (addr_hi),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .rom_cs_n  (rom_cs_n),
        .ram0_cs_n (ram0_cs_n),
        .ram1_cs_n (ram1_cs_n),
        .ready     (ready),
        .ready_oe  (ready_oe)
    );

    function automatic bit exp_rom(input logic [4:0] a, input logic rdn);
        return (rdn == 1'b0) && (a[4:2] == 3'b000);
    endfunction

    function automatic bit exp_ram(input logic [4:0] a, input logic rdn,
                                   input logic wrn, input logic bank);
        return ((rdn == 1'b0) || (wrn == 1'b0)) && (a == {4'b0010, bank});
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag,
                       input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %b exp %b", tag, what, got, exp);
        end
    endtask

    // One bus cycle: drive, check before the edge, then advance the model
    task automatic cycle(input logic r, input logic [4:0] a, input logic rdn,
                         input logic wrn, input string tag);
        bit rom;
        @(negedge clk);
        rst = r; addr_hi = a; rd_n = rdn; wr_n = wrn;
        #1;
        rom = exp_rom(a, rdn);
        chk(rom_cs_n,  ~rom, "R1", "rom_cs_n");
        chk(ram0_cs_n, ~exp_ram(a, rdn, wrn, 1'b0), "R2", "ram0_cs_n");
        chk(ram1_cs_n, ~exp_ram(a, rdn, wrn, 1'b1), "R3", "ram1_cs_n");
        chk(ready_oe, rom, rom ? "R4" : "R8", "ready_oe");
        if (valid) chk(ready, (cnt >= 2), tag, "ready");
        @(posedge clk);
        if (r) begin
            cnt = 0; valid = 1'b1;
        end else if (rom) begin
            cnt = (cnt < 2) ? cnt + 1 : 2;
        end else begin
            cnt = 0;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [4:0] ra;
        logic       rrd, rwr, rrst;
        void'($urandom(32'd1234));

        // R7: reset cycles
        for (int i = 0; i < 3; i++) cycle(1'b1, 5'b00000, 1'b1, 1'b1, "R7");
        // reset state, idle bus
        cycle(1'b0, 5'b11111, 1'b1, 1'b1, "R5");
        chk(ready, 1'b0, "R7", "ready after reset");

        // R6: ROM read held five cycles: 0,0,1,1,1
        for (int i = 0; i < 5; i++) cycle(1'b0, 5'b00011, 1'b0, 1'b1, "R6");
        chk(ready, 1'b1, "R6", "ready late in held read");

        // R9: one idle cycle then a new ROM read
        cycle(1'b0, 5'b00011, 1'b1, 1'b1, "R9");
        for (int i = 0; i < 3; i++) cycle(1'b0, 5'b00001, 1'b0, 1'b1, "R9");
        // R9: move to a RAM address mid-read, then back
        cycle(1'b0, 5'b00100, 1'b0, 1'b1, "R9");
        for (int i = 0; i < 3; i++) cycle(1'b0, 5'b00010, 1'b0, 1'b1, "R9");

        // R1/R8: write into the ROM window
        cycle(1'b0, 5'b00000, 1'b1, 1'b0, "R8");
        // R2/R3: RAM bank reads and writes, unmapped accesses
        cycle(1'b0, 5'b00100, 1'b0, 1'b1, "R2");
        cycle(1'b0, 5'b00100, 1'b1, 1'b0, "R2");
        cycle(1'b0, 5'b00101, 1'b0, 1'b1, "R3");
        cycle(1'b0, 5'b00101, 1'b1, 1'b0, "R3");
        cycle(1'b0, 5'b00110, 1'b0, 1'b0, "R8");
        cycle(1'b0, 5'b01100, 1'b0, 1'b1, "R8");
        cycle(1'b0, 5'b10101, 1'b1, 1'b0, "R8");

        // R7: reset during a held ROM read
        for (int i = 0; i < 3; i++) cycle(1'b0, 5'b00000, 1'b0, 1'b1, "R6");
        for (int i = 0; i < 2; i++) cycle(1'b1, 5'b00000, 1'b0, 1'b1, "R7");
        for (int i = 0; i < 4; i++) cycle(1'b0, 5'b00000, 1'b0, 1'b1, "R7");

        // Random traffic with sticky inputs
        ra = 5'b00000; rrd = 1'b0; rwr = 1'b1; rrst = 1'b0;
        for (int i = 0; i < 500; i++) begin
            if ($urandom_range(0, 99) >= 65) begin
                if ($urandom_range(0, 1) == 0) ra = 5'($urandom_range(0, 5));
                else ra = 5'($urandom);
                rrd = 1'($urandom_range(0, 2) != 0 ? 0 : 1);
                rwr = 1'($urandom);
            end
            rrst = ($urandom_range(0, 59) == 0);
            cycle(rrst, ra, rrd, rwr, rrst ? "R7" : "R6");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule